// File: doc/BRIEF.md
# Prioritized Maskable Interrupt Controller

The block gathers level-sensitive interrupt request lines from several devices and one non-maskable line. Each device line has a fixed rank, with the line index as the rank. The block passes only one request to the processor at a time. It raises the processor request only when the best pending source outranks the level now in service. Lower and equal requests stay pending until the running service completes.

When the processor accepts, the block saves the old level on a small in-service stack and adopts the granted source's level. It pulses that source's acknowledge for one cycle. A completion pulse restores the saved level, so nested service unwinds in order. A global enable gates every device line. The non-maskable line is never gated by the enable.

Top module: `prio_irq_ctrl`

## Requirements
- R1: Reset state: while and right after reset, cur_level is 0 (idle), cpu_irq is low, every acknowledge output is low and pend_valid is low.
- R2: Every request input, the non-maskable one included, passes two flops before it has any effect. A request that goes high shows on pend_valid and cpu_irq after the second rising edge, and not after the first.
- R3: The highest-index enabled device line that is pending wins. pend_id gives its index (0..NUM_SRC-1), or NUM_SRC when the non-maskable line is pending, and pend_valid marks that any source is pending.
- R4: Level codes are 0 for idle, i+1 for device line i, and NUM_SRC+1 for the non-maskable line. cpu_irq is high only when the winning pending level is strictly greater than cur_level, so equal and lower levels are held.
- R5: At a rising edge with cpu_ack and cpu_irq high and eoi low, the winner is granted. After that edge, cur_level holds the granted level. Exactly one acknowledge output (dev_ack bit i, or nmi_ack) is high for that one cycle only.
- R6: Each eoi pulse with a non-idle cur_level restores the level that was current before the last grant. Up to NUM_SRC+1 nested grants unwind in reverse order.
- R7: An eoi while cur_level is 0 is ignored: the level stays 0 and a later grant and completion behave normally.
- R8: When irq_en is low, no device line is pending. The non-maskable line still is pending and still raises cpu_irq.
- R9: The non-maskable line outranks every device line and preempts any device service. It is held only while a non-maskable service is itself in progress.
- R10: A cpu_ack while cpu_irq is low has no effect: no acknowledge pulse and no change of cur_level.
- R11: When eoi and cpu_ack are high at the same edge, only the completion takes effect, and no grant or acknowledge occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_en | input | 1 | Global enable for device lines |
| dev_req | input | NUM_SRC | Device request lines, level-sensitive, bit i is rank i |
| nmi_req | input | 1 | Non-maskable request, level-sensitive |
| cpu_ack | input | 1 | Processor accepts the raised request |
| eoi | input | 1 | End of current service |
| cpu_irq | output | 1 | Request to the processor |
| dev_ack | output | NUM_SRC | One-cycle acknowledge per device |
| nmi_ack | output | 1 | One-cycle acknowledge for the non-maskable line |
| cur_level | output | clog2(NUM_SRC+2) | Level in service, 0 when idle |
| pend_valid | output | 1 | Some enabled source is pending |
| pend_id | output | clog2(NUM_SRC+1) | Winning pending source |

## Verification
A request change reaches pend_valid, pend_id and cpu_irq two edges after it is driven, so the bench checks one edge later for the old value and two edges later for the new one. The acknowledge pulse and the new cur_level are due right after the accepting edge, and the pulse is gone one edge after that. An eoi changes cur_level at the next edge. A change to irq_en, or to the level in service, reaches cpu_irq within the same cycle. Inputs are driven 1 ns after a rising edge and outputs are read at that point, so every value read has settled after the intended edge.

// File: rtl/intc_pkg.sv
package intc_pkg;

    typedef enum logic [1:0] {
        STK_HOLD = 2'd0,
        STK_PUSH = 2'd1,
        STK_POP  = 2'd2
    } stk_op_e;

    // level code of a device line index
    function automatic int line_level(input int idx);
        return idx + 1;
    endfunction

endpackage

// File: rtl/intc_sync.sv
module intc_sync #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/intc_pick.sv
module intc_pick
    import intc_pkg::*;
#(
    parameter int N     = 4,
    parameter int ID_W  = 3,
    parameter int LVL_W = 3
) (
    input  logic             en,
    input  logic [N-1:0]     req,
    input  logic             nmi,
    output logic             valid,
    output logic [ID_W-1:0]  id,
    output logic [LVL_W-1:0] lvl
);
    always_comb begin
        valid = 1'b0;
        id    = '0;
        lvl   = '0;
        for (int i = 0; i < N; i++) begin
            if (en && req[i]) begin
                valid = 1'b1;
                id    = ID_W'(i);
                lvl   = LVL_W'(line_level(i));
            end
        end
        if (nmi) begin
            valid = 1'b1;
            id    = ID_W'(N);
            lvl   = LVL_W'(N + 1);
        end
    end
endmodule

// File: rtl/intc_lvl_stack.sv
module intc_lvl_stack
    import intc_pkg::*;
#(
    parameter int DEPTH = 5,
    parameter int LVL_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  stk_op_e          op,
    input  logic [LVL_W-1:0] new_lvl,
    output logic [LVL_W-1:0] cur_lvl,
    output logic             empty
);
    localparam int SP_W = $clog2(DEPTH + 1);

    logic [LVL_W-1:0] saved [DEPTH];
    logic [SP_W-1:0]  sp;

    assign empty = (sp == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            sp      <= '0;
            cur_lvl <= '0;
            for (int i = 0; i < DEPTH; i++) saved[i] <= '0;
        end else begin
            case (op)
                STK_PUSH: begin
                    if (sp < SP_W'(DEPTH)) begin
                        saved[sp] <= cur_lvl;
                        sp        <= sp + 1'b1;
                        cur_lvl   <= new_lvl;
                    end
                end
                STK_POP: begin
                    if (!empty) begin
                        cur_lvl <= saved[sp - 1'b1];
                        sp      <= sp - 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import intc_pkg::*;
#(
    parameter  int NUM_SRC = 4,
    localparam int LVL_W   = $clog2(NUM_SRC + 2),
    localparam int ID_W    = $clog2(NUM_SRC + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               irq_en,
    input  logic [NUM_SRC-1:0] dev_req,
    input  logic               nmi_req,
    input  logic               cpu_ack,
    input  logic               eoi,
    output logic               cpu_irq,
    output logic [NUM_SRC-1:0] dev_ack,
    output logic               nmi_ack,
    output logic [LVL_W-1:0]   cur_level,
    output logic               pend_valid,
    output logic [ID_W-1:0]    pend_id
);
    localparam int DEPTH = NUM_SRC + 1;

    logic [NUM_SRC:0]   req_s;
    logic [LVL_W-1:0]   pend_lvl;
    logic               stk_empty;
    logic               grant;
    stk_op_e            op;

    intc_sync #(.W(NUM_SRC + 1)) sync_i (
        .clk (clk),
        .rst (rst),
        .d   ({nmi_req, dev_req}),
        .q   (req_s)
    );

    intc_pick #(.N(NUM_SRC), .ID_W(ID_W), .LVL_W(LVL_W)) pick_i (
        .en    (irq_en),
        .req   (req_s[NUM_SRC-1:0]),
        .nmi   (req_s[NUM_SRC]),
        .valid (pend_valid),
        .id    (pend_id),
        .lvl   (pend_lvl)
    );

    assign cpu_irq = pend_valid && (pend_lvl > cur_level);
    assign grant   = cpu_ack && cpu_irq && !eoi;

    always_comb begin
        if (eoi)        op = STK_POP;
        else if (grant) op = STK_PUSH;
        else            op = STK_HOLD;
    end

    intc_lvl_stack #(.DEPTH(DEPTH), .LVL_W(LVL_W)) stack_i (
        .clk     (clk),
        .rst     (rst),
        .op      (op),
        .new_lvl (pend_lvl),
        .cur_lvl (cur_level),
        .empty   (stk_empty)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            dev_ack <= '0;
            nmi_ack <= 1'b0;
        end else begin
            for (int i = 0; i < NUM_SRC; i++)
                dev_ack[i] <= grant && (pend_id == ID_W'(i));
            nmi_ack <= grant && (pend_id == ID_W'(NUM_SRC));
        end
    end
endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk #(
    parameter int N     = 4,
    parameter int LVL_W = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             cpu_irq,
    input logic             cpu_ack,
    input logic             eoi,
    input logic             pend_valid,
    input logic [N-1:0]     dev_ack,
    input logic             nmi_ack,
    input logic [LVL_W-1:0] cur_level
);
    logic grant_seen;
    assign grant_seen = cpu_ack && cpu_irq && !eoi;

    assert_irq_needs_pending_R4: assert property (@(posedge clk) disable iff (rst)
        cpu_irq |-> pend_valid);

    assert_ack_onehot_R5: assert property (@(posedge clk) disable iff (rst)
        $onehot0({nmi_ack, dev_ack}));

    assert_grant_acks_R5: assert property (@(posedge clk) disable iff (rst)
        grant_seen |=> ($countones({nmi_ack, dev_ack}) == 1));

    assert_grant_raises_R5: assert property (@(posedge clk) disable iff (rst)
        grant_seen |=> (cur_level > $past(cur_level)));

    assert_no_stray_ack_R10: assert property (@(posedge clk) disable iff (rst)
        !grant_seen |=> ({nmi_ack, dev_ack} == '0));

    assert_eoi_lowers_R6: assert property (@(posedge clk) disable iff (rst)
        (eoi && cur_level != '0) |=> (cur_level < $past(cur_level)));

    assert_eoi_idle_R7: assert property (@(posedge clk) disable iff (rst)
        (eoi && cur_level == '0) |=> (cur_level == '0));

    assert_level_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (!cpu_ack && !eoi) |=> $stable(cur_level));
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(.N(NUM_SRC), .LVL_W(LVL_W)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .cpu_irq    (cpu_irq),
    .cpu_ack    (cpu_ack),
    .eoi        (eoi),
    .pend_valid (pend_valid),
    .dev_ack    (dev_ack),
    .nmi_ack    (nmi_ack),
    .cur_level  (cur_level)
);

// File: tb/prio_irq_ctrl_tb_top.sv
module prio_irq_ctrl_tb_top;
    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst;
    logic         irq_en;
    logic [N-1:0] dev_req;
    logic         nmi_req;
    logic         cpu_ack;
    logic         eoi;
    logic         cpu_irq;
    logic [N-1:0] dev_ack;
    logic         nmi_ack;
    logic [2:0]   cur_level;
    logic         pend_valid;
    logic [2:0]   pend_id;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    prio_irq_ctrl #(.NUM_SRC(N)) dut_i (
        .clk(clk), .rst(rst), .irq_en(irq_en), .dev_req(dev_req),
        .nmi_req(nmi_req), .cpu_ack(cpu_ack), .eoi(eoi), .cpu_irq(cpu_irq),
        .dev_ack(dev_ack), .nmi_ack(nmi_ack), .cur_level(cur_level),
        .pend_valid(pend_valid), .pend_id(pend_id)
    );

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input string what,
                         input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic grant_once;
        cpu_ack = 1'b1;
        tick(1);
        cpu_ack = 1'b0;
    endtask

    task automatic clean;
        dev_req = '0; nmi_req = 1'b0; irq_en = 1'b1; cpu_ack = 1'b0;
        eoi = 1'b1;
        tick(N + 2);
        eoi = 1'b0;
        tick(2);
    endtask

    task automatic t_reset;
        rst = 1'b1; irq_en = 1'b1; dev_req = '0; nmi_req = 1'b0;
        cpu_ack = 1'b0; eoi = 1'b0;
        tick(3);
        check("R1", "cur_level in reset", int'(cur_level), 0);
        rst = 1'b0;
        tick(1);
        check("R1", "cpu_irq", int'(cpu_irq), 0);
        check("R1", "acks", int'({nmi_ack, dev_ack}), 0);
        check("R1", "pend_valid", int'(pend_valid), 0);
        check("R1", "cur_level", int'(cur_level), 0);
    endtask

    task automatic t_sync_and_pick;
        clean();
        dev_req = 4'b0010;
        tick(1);
        check("R2", "cpu_irq after one edge", int'(cpu_irq), 0);
        tick(1);
        check("R2", "cpu_irq after two edges", int'(cpu_irq), 1);
        check("R3", "pend_id single", int'(pend_id), 1);
        dev_req = 4'b0101;
        tick(2);
        check("R3", "pend_id highest", int'(pend_id), 2);
        check("R3", "pend_valid", int'(pend_valid), 1);
    endtask

    task automatic t_grant;
        clean();
        dev_req = 4'b0101;
        tick(2);
        grant_once();
        check("R5", "dev_ack pulse", int'(dev_ack), 4);
        check("R5", "nmi_ack", int'(nmi_ack), 0);
        check("R5", "cur_level", int'(cur_level), 3);
        check("R4", "equal and lower held", int'(cpu_irq), 0);
        tick(1);
        check("R5", "dev_ack one cycle", int'(dev_ack), 0);
        dev_req = 4'b1101;
        tick(2);
        check("R4", "higher raises irq", int'(cpu_irq), 1);
        grant_once();
        check("R5", "nested cur_level", int'(cur_level), 4);
        eoi = 1'b1; tick(1); eoi = 1'b0;
        check("R6", "pop to previous", int'(cur_level), 3);
        eoi = 1'b1; tick(1); eoi = 1'b0;
        check("R6", "pop to idle", int'(cur_level), 0);
        check("R4", "pending line outranks idle", int'(cpu_irq), 1);
    endtask

    task automatic t_deep_nest;
        clean();
        for (int i = 0; i < N; i++) begin
            dev_req[i] = 1'b1;
            tick(2);
            grant_once();
            check("R6", "nest level", int'(cur_level), i + 1);
        end
        nmi_req = 1'b1;
        tick(2);
        grant_once();
        check("R6", "nest nmi level", int'(cur_level), N + 1);
        for (int i = N; i >= 0; i--) begin
            eoi = 1'b1; tick(1); eoi = 1'b0;
            check("R6", "unwind level", int'(cur_level), i);
        end
    endtask

    task automatic t_eoi_idle;
        clean();
        eoi = 1'b1; tick(2); eoi = 1'b0;
        check("R7", "idle eoi keeps level", int'(cur_level), 0);
        dev_req = 4'b0010;
        tick(2);
        grant_once();
        check("R7", "grant after idle eoi", int'(cur_level), 2);
        eoi = 1'b1; tick(1); eoi = 1'b0;
        check("R7", "pop after idle eoi", int'(cur_level), 0);
    endtask

    task automatic t_enable;
        clean();
        irq_en = 1'b0;
        dev_req = 4'b1000;
        tick(3);
        check("R8", "masked irq", int'(cpu_irq), 0);
        check("R8", "masked pend_valid", int'(pend_valid), 0);
        nmi_req = 1'b1;
        tick(2);
        check("R8", "nmi ignores enable", int'(cpu_irq), 1);
        check("R8", "nmi id", int'(pend_id), N);
        nmi_req = 1'b0;
        irq_en = 1'b1;
        tick(2);
        check("R8", "line back after enable", int'(pend_id), 3);
    endtask

    task automatic t_nmi;
        clean();
        dev_req = 4'b1000;
        tick(2);
        grant_once();
        tick(1);
        nmi_req = 1'b1;
        tick(2);
        check("R9", "nmi preempts line3", int'(cpu_irq), 1);
        grant_once();
        check("R9", "nmi_ack", int'(nmi_ack), 1);
        check("R9", "no dev_ack", int'(dev_ack), 0);
        check("R9", "nmi level", int'(cur_level), N + 1);
        check("R9", "nmi held in nmi service", int'(cpu_irq), 0);
        tick(1);
        eoi = 1'b1; tick(1); eoi = 1'b0;
        check("R9", "nmi again after pop", int'(cpu_irq), 1);
    endtask

    task automatic t_stray_ack;
        clean();
        cpu_ack = 1'b1; tick(1); cpu_ack = 1'b0;
        check("R10", "no ack", int'({nmi_ack, dev_ack}), 0);
        check("R10", "level unchanged", int'(cur_level), 0);
    endtask

    task automatic t_eoi_and_ack;
        clean();
        dev_req = 4'b0010;
        tick(2);
        grant_once();
        dev_req = 4'b1000;
        tick(3);
        cpu_ack = 1'b1; eoi = 1'b1;
        tick(1);
        cpu_ack = 1'b0; eoi = 1'b0;
        check("R11", "completion taken", int'(cur_level), 0);
        check("R11", "no ack", int'({nmi_ack, dev_ack}), 0);
        check("R11", "request still raised", int'(cpu_irq), 1);
    endtask

    initial begin
        #(8 * 20000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_sync_and_pick();
        t_grant();
        t_deep_nest();
        t_eoi_idle();
        t_enable();
        t_nmi();
        t_stray_ack();
        t_eoi_and_ack();
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule